// File: doc/BRIEF.md
# Microsecond Down-Timer with One-Shot and Periodic Modes

This block is a single timer channel on a plain register port. Software writes one 32-bit control word that carries three fields: an enable flag, a mode flag that picks periodic or one-shot operation, and a 29-bit count. While enabled, the channel counts down by one on every pulse of an external microsecond strobe. When a strobe arrives while the count is already zero, the channel raises an active-high, level-sensitive interrupt.

The count field holds the wanted interval minus one, so a value of N gives an interrupt on the (N+1)-th strobe after the write. In one-shot mode the channel then clears its own enable flag and stops. In periodic mode it reloads the programmed count and keeps running. The interrupt stays high until software writes a one to the acknowledge bit of a separate register. A status register returns the live count. The strobe generator is outside this block. The register port has no handshake: a write takes effect on the clock edge where `wr_en` is high, and `rdata` follows `addr` combinationally.

Top module: `usec_down_timer`

## Requirements
- R1: After reset, `irq` is 0, the control register reads 0, the live count reads 0 and the channel is disabled.
- R2: A write with `addr`=0 stores the whole 32-bit word in the control register. Bit 31 is enable, bit 30 is periodic mode, and bits 28..0 are the count. The same write loads the live count from bits 28..0. Reading `addr`=0 returns the stored word.
- R3: While enabled, each `tick` pulse with a nonzero count lowers the live count by one. While disabled, `tick` leaves the count unchanged.
- R4: A `tick` that arrives while enabled with a live count of 0 sets `irq` on the following clock edge. For a programmed count N, this is the (N+1)-th tick after the write.
- R5: In one-shot mode (bit 30 = 0), expiry clears bit 31 of the stored control word. The count then stays at 0 through further ticks.
- R6: In periodic mode (bit 30 = 1), expiry reloads the live count from bits 28..0 and leaves bit 31 set, so `irq` recurs every N+1 ticks.
- R7: `irq` stays high until a write to `addr`=1 with bit 30 set. A write to `addr`=1 with bit 30 clear leaves `irq` unchanged.
- R8: When an expiry and an acknowledge write fall in the same cycle, the expiry wins and `irq` is 1 afterwards.
- R9: When a control write and a `tick` fall in the same cycle, the write wins and the tick is discarded.
- R10: `addr`=2 reads the live count in bits 28..0 with zeros above. `addr`=1 reads the pending flag at bit 30. `addr`=3 reads 0 and ignores writes.
- R11: Writing 0 to the control register disables the channel without touching a pending `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle microsecond strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 acknowledge/pending, 2 live count, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, active high |

## Verification
Two pairs of events can land in the same cycle. An expiry can meet an acknowledge write: the bench programs a periodic count of 0, so every tick expires, and it drives the acknowledge write together with the tick. It then expects `irq` to remain high, and to drop only after a later, lone acknowledge. A control write can meet a tick: the bench sends a new count together with a tick and expects the live count to equal the written value exactly, not one less.

// File: rtl/usec_tmr_pkg.sv
package usec_tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_LIVE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/usec_tmr_regdec.sv
module usec_tmr_regdec
  import usec_tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int ACK_BIT = 30
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [CNT_W-1:0]  live_q,
  input  logic              pend_q,
  output logic              ctrl_we,
  output logic              ack_we,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;
  logic [DATA_W-1:0] live_word;
  logic [DATA_W-1:0] pend_word;

  assign sel = reg_sel_e'(addr);

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign live_word = {{(DATA_W-CNT_W){1'b0}}, live_q};
    end else begin : g_full
      assign live_word = live_q[DATA_W-1:0];
    end
  endgenerate

  assign pend_word = DATA_W'(pend_q) << ACK_BIT;

  always_comb begin
    ctrl_we = 1'b0;
    ack_we  = 1'b0;
    rdata   = '0;
    case (sel)
      SEL_CTRL: begin ctrl_we = wr_en; rdata = ctrl_q;    end
      SEL_ACK:  begin ack_we  = wr_en; rdata = pend_word; end
      SEL_LIVE: rdata = live_word;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/usec_tmr_count.sv
module usec_tmr_count #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int EN_BIT  = 31,
  parameter int PER_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  live_q,
  output logic              expire
);
  logic running;
  logic at_zero;

  assign running = ctrl_q[EN_BIT];
  assign at_zero = (live_q == '0);
  assign expire  = tick && running && at_zero && !ctrl_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      live_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata;
      live_q <= wdata[CNT_W-1:0];
    end else if (tick && running) begin
      if (at_zero) begin
        if (ctrl_q[PER_BIT]) live_q <= ctrl_q[CNT_W-1:0];
        else                 ctrl_q[EN_BIT] <= 1'b0;
      end else begin
        live_q <= live_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/usec_tmr_irq.sv
module usec_tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack_we,
  input  logic ack_bit,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (expire)           pend_q <= 1'b1;
    else if (ack_we && ack_bit) pend_q <= 1'b0;
  end
endmodule

// File: rtl/usec_down_timer.sv
module usec_down_timer #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int EN_BIT  = 31,
  parameter int PER_BIT = 30,
  parameter int ACK_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              ctrl_we;
  logic              ack_we;
  logic              expire;
  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  live_q;

  usec_tmr_regdec #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ACK_BIT(ACK_BIT)) u_dec (
    .wr_en(wr_en), .addr(addr), .ctrl_q(ctrl_q), .live_q(live_q),
    .pend_q(irq), .ctrl_we(ctrl_we), .ack_we(ack_we), .rdata(rdata)
  );

  usec_tmr_count #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
                   .PER_BIT(PER_BIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we),
    .wdata(wdata), .ctrl_q(ctrl_q), .live_q(live_q), .expire(expire)
  );

  usec_tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack_we(ack_we),
    .ack_bit(wdata[ACK_BIT]), .pend_q(irq)
  );
endmodule

// File: rtl/usec_tmr_checker.sv
module usec_tmr_checker #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctrl_we,
  input logic             ack_we,
  input logic             ack_bit,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             wr_en_bit,
  input logic             en_q,
  input logic             per_q,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] live_q,
  input logic             irq
);
  logic hit;
  assign hit = tick && en_q && (live_q == '0) && !ctrl_we;

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (live_q == $past(wr_cnt)) && (en_q == $past(wr_en_bit)));

  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && live_q != '0 && !ctrl_we) |=> live_q == $past(live_q) - CNT_W'(1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_we) |=> $stable(live_q));

  assert_expire_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq);

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !per_q) |=> !en_q);

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q) |=> en_q && live_q == $past(reload));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ack_we && ack_bit)) |=> irq);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_bit && !hit) |=> !irq);
endmodule

bind usec_down_timer usec_tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we), .ack_we(ack_we),
  .ack_bit(wdata[ACK_BIT]), .wr_cnt(wdata[CNT_W-1:0]), .wr_en_bit(wdata[EN_BIT]),
  .en_q(ctrl_q[EN_BIT]), .per_q(ctrl_q[PER_BIT]), .reload(ctrl_q[CNT_W-1:0]),
  .live_q(live_q), .irq(irq)
);

// File: tb/sim_usec_down_timer.sv
`timescale 1ns/1ps
module sim_usec_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] PER = 32'h4000_0000;
  localparam logic [31:0] ACK = 32'h4000_0000;

  always #10 clk = ~clk;

  usec_down_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                     input logic tk);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    wr_en = 1'b0; addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(2'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(2'd2, v); chk("R1 live", v, 32'd0);

    // One-shot sweep: R2 R3 R4 R5 R7
    for (int n = 0; n < 6; n++) begin
      cyc(1'b1, 2'd0, EN | 32'(n), 1'b0);
      rd(2'd0, v); chk("R2 ctrl readback", v, EN | 32'(n));
      rd(2'd2, v); chk("R2 live load", v, 32'(n));
      for (int k = 1; k <= n; k++) begin
        cyc(1'b0, 2'd0, 32'd0, 1'b1);
        rd(2'd2, v); chk("R3 decrement", v, 32'(n - k));
        chk("R4 no early irq", {31'd0, irq}, 32'd0);
      end
      cyc(1'b0, 2'd0, 32'd0, 1'b1);
      chk("R4 irq on tick n+1", {31'd0, irq}, 32'd1);
      rd(2'd0, v); chk("R5 enable cleared", v, 32'(n));
      cyc(1'b0, 2'd0, 32'd0, 1'b1);
      rd(2'd2, v); chk("R5 count stays 0", v, 32'd0);
      rd(2'd1, v); chk("R10 pending bit30", v, 32'h4000_0000);
      cyc(1'b1, 2'd1, 32'd0, 1'b0);
      chk("R7 ack without bit30 ignored", {31'd0, irq}, 32'd1);
      cyc(1'b1, 2'd1, ACK, 1'b0);
      chk("R7 ack clears", {31'd0, irq}, 32'd0);
    end

    // Periodic sweep: R6
    for (int n = 0; n < 5; n++) begin
      cyc(1'b1, 2'd0, EN | PER | 32'(n), 1'b0);
      for (int p = 0; p < 2; p++) begin
        for (int k = 1; k <= n; k++) begin
          cyc(1'b0, 2'd0, 32'd0, 1'b1);
          chk("R6 no irq mid-period", {31'd0, irq}, 32'd0);
        end
        cyc(1'b0, 2'd0, 32'd0, 1'b1);
        chk("R6 irq each period", {31'd0, irq}, 32'd1);
        rd(2'd2, v); chk("R6 reload count", v, 32'(n));
        rd(2'd0, v); chk("R6 stays enabled", v, EN | PER | 32'(n));
        cyc(1'b1, 2'd1, ACK, 1'b0);
        chk("R7 ack clears periodic", {31'd0, irq}, 32'd0);
      end
    end

    // R8: expiry and ack in the same cycle (periodic count 0 expires every tick)
    cyc(1'b1, 2'd0, EN | PER, 1'b0);
    cyc(1'b1, 2'd1, ACK, 1'b1);
    chk("R8 expiry beats ack", {31'd0, irq}, 32'd1);
    cyc(1'b1, 2'd1, ACK, 1'b0);
    chk("R8 lone ack clears", {31'd0, irq}, 32'd0);

    // R9: control write and tick in the same cycle
    cyc(1'b1, 2'd0, EN | 32'd3, 1'b0);
    cyc(1'b1, 2'd0, EN | 32'd7, 1'b1);
    rd(2'd2, v); chk("R9 write beats tick", v, 32'd7);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    rd(2'd2, v); chk("R9 next tick counts", v, 32'd6);

    // R3: disabled channel ignores ticks
    cyc(1'b1, 2'd0, 32'd5, 1'b0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 2'd0, 32'd0, 1'b1);
    rd(2'd2, v); chk("R3 disabled holds", v, 32'd5);
    chk("R3 disabled no irq", {31'd0, irq}, 32'd0);

    // R11: writing zero keeps a pending irq
    cyc(1'b1, 2'd0, EN, 1'b0);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    cyc(1'b1, 2'd0, 32'd0, 1'b0);
    rd(2'd0, v); chk("R11 ctrl zero", v, 32'd0);
    chk("R11 irq kept", {31'd0, irq}, 32'd1);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    rd(2'd2, v); chk("R11 stopped", v, 32'd0);

    // R10: unused address
    cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0);
    rd(2'd3, v); chk("R10 addr3 reads 0", v, 32'd0);
    rd(2'd0, v); chk("R10 addr3 write ignored", v, 32'd0);
    chk("R10 addr3 irq untouched", {31'd0, irq}, 32'd1);
    cyc(1'b1, 2'd1, ACK, 1'b0);
    rd(2'd1, v); chk("R10 pending reads 0", v, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule